// File: doc/BRIEF.md
# Auto-Incrementing Board Identification Reader

This block is a read-only identification port. A host reads a fixed 256-entry byte table through an internal pointer that steps forward after every read, so software obtains the whole identity record by reading one address over and over. Two neighbouring data offsets return table bytes. The low data offset puts the byte in the low lane and the high data offset puts it in the high lane. A 16-bit access at either data offset returns two consecutive entries and steps the pointer by two. A read of a third offset rewinds the pointer to the start of the table.

The table holds a device code, a vendor code, two revision digits, four don't-care bytes, an eight-character ASCII board name, two NUL pad bytes and FFh fill up to the end. The host keeps its read strobe high for as long as the access lasts, which may be several clock cycles. The pointer moves once, on the cycle in which the strobe drops. The port has no back-pressure: a read is never stalled, and read data is valid for every cycle the strobe is high. Address decoding for the register bus sits outside this block, which sees only a local offset.

Top module: `id_port`

## Requirements
- R1: After reset the pointer is zero, so the first data read returns entry 0 (60h).
- R2: Any read at the rewind offset (802h) returns 0000h on rd_data and sets the pointer to zero once the strobe drops.
- R3: A byte read (rd_wide low) at the low data offset (800h) returns the entry at the pointer in bits 7:0 with bits 15:8 zero, and then advances the pointer by one.
- R4: A byte read at the high data offset (801h) returns the entry at the pointer in bits 15:8 with bits 7:0 zero, and then advances the pointer by one.
- R5: Entries 0, 1, 2 and 3 hold 60h, 61h, 35h and 14h.
- R6: Entry 4 holds the low revision digit (default 03h), entry 5 the high revision digit (default 01h), and entries 6 to 9 the don't-care value (default 00h).
- R7: Entries 10 to 17 hold the ASCII board name "NAVIO-16", first character at entry 10. Entries 18 and 19 hold 00h, and entries 20 to 255 hold FFh.
- R8: A 16-bit read (rd_wide high) at either data offset returns entry P in bits 7:0 and entry P+1 in bits 15:8, and then advances the pointer by two.
- R9: The pointer is 8 bits wide and wraps from 255 to 0. A 16-bit read at pointer 255 returns entry 0 in its high byte.
- R10: The pointer steps once per strobe, on the clock edge where the strobe is first seen low. A strobe held for several cycles counts once, and rd_data stays constant while it is held.
- R11: rd_data is 0000h while the strobe is low. A read at any offset other than 800h, 801h or 802h returns 0000h and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | Read strobe, high for the length of an access |
| rd_addr | input | 12 | Local register offset of the access |
| rd_wide | input | 1 | High for a 16-bit access, low for a byte access |
| rd_data | output | 16 | Read data, valid while rd_strobe is high |

## Verification
The assertions assume that rd_addr and rd_wide stay steady from the first cycle of a strobe until the cycle it drops. The checker takes the access kind from its own copy of those inputs, captured when the strobe rises, so a change in mid-access would not be modelled. The bench drives every access on a falling clock edge and changes address and width only while the strobe is low. It always leaves at least one low cycle between accesses, so each fall is seen as a separate event.

// File: rtl/id_port_pkg.sv
package id_port_pkg;

  typedef enum logic [2:0] {
    ACC_NONE   = 3'd0,
    ACC_LO     = 3'd1,
    ACC_HI     = 3'd2,
    ACC_WORD   = 3'd3,
    ACC_REWIND = 3'd4
  } acc_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 2;

endpackage

// File: rtl/id_port_decode.sv
module id_port_decode #(
  parameter int unsigned        ADDR_W     = 12,
  parameter logic [ADDR_W-1:0]  LO_OFS     = 12'h800,
  parameter logic [ADDR_W-1:0]  HI_OFS     = 12'h801,
  parameter logic [ADDR_W-1:0]  REWIND_OFS = 12'h802
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output id_port_pkg::acc_e kind
);
  import id_port_pkg::*;

  always_comb begin
    kind = ACC_NONE;
    if (addr == REWIND_OFS) begin
      kind = ACC_REWIND;
    end else if (addr == LO_OFS || addr == HI_OFS) begin
      if (wide)                kind = ACC_WORD;
      else if (addr == LO_OFS) kind = ACC_LO;
      else                     kind = ACC_HI;
    end
  end

endmodule

// File: rtl/id_port_strobe.sv
module id_port_strobe (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  id_port_pkg::acc_e kind_now,
  output logic              step,
  output id_port_pkg::acc_e step_kind
);
  import id_port_pkg::*;

  logic strobe_q;
  acc_e held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      held_q   <= ACC_NONE;
    end else begin
      strobe_q <= strobe;
      if (strobe && !strobe_q) held_q <= kind_now;
    end
  end

  assign step      = strobe_q && !strobe;
  assign step_kind = held_q;

endmodule

// File: rtl/id_port_ptr.sv
module id_port_ptr #(
  parameter int unsigned PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  id_port_pkg::acc_e step_kind,
  output logic [PTR_W-1:0]  ptr
);
  import id_port_pkg::*;

  localparam logic [PTR_W-1:0] STEP_BYTE = PTR_W'(1);
  localparam logic [PTR_W-1:0] STEP_WORD = PTR_W'(LANES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (step) begin
      unique case (step_kind)
        ACC_REWIND:     ptr <= '0;
        ACC_LO, ACC_HI: ptr <= ptr + STEP_BYTE;
        ACC_WORD:       ptr <= ptr + STEP_WORD;
        default:        ptr <= ptr;
      endcase
    end
  end

endmodule

// File: rtl/id_port_rom.sv
module id_port_rom #(
  parameter int unsigned PTR_W    = 8,
  parameter logic [15:0] DEV_CODE = 16'h6160,
  parameter logic [15:0] VEN_CODE = 16'h1435,
  parameter logic [7:0]  REV_LO   = 8'h03,
  parameter logic [7:0]  REV_HI   = 8'h01,
  parameter logic [7:0]  DC_BYTE  = 8'h00,
  parameter logic [63:0] NAME     = "NAVIO-16",
  parameter logic [7:0]  PAD_BYTE = 8'h00,
  parameter logic [7:0]  FILL     = 8'hFF
) (
  input  logic [PTR_W-1:0] ptr,
  output logic [id_port_pkg::LANES-1:0][7:0] lane
);
  import id_port_pkg::*;

  localparam int NAME_FIRST = 10;
  localparam int NAME_LAST  = NAME_FIRST + 7;
  localparam int PAD_LAST   = NAME_LAST + 2;

  function automatic logic [7:0] entry(input logic [PTR_W-1:0] i);
    int idx;
    idx = int'(i);
    if (idx == 0)                  return DEV_CODE[7:0];
    else if (idx == 1)             return DEV_CODE[15:8];
    else if (idx == 2)             return VEN_CODE[7:0];
    else if (idx == 3)             return VEN_CODE[15:8];
    else if (idx == 4)             return REV_LO;
    else if (idx == 5)             return REV_HI;
    else if (idx < NAME_FIRST)     return DC_BYTE;
    else if (idx <= NAME_LAST)     return NAME[8*(NAME_LAST-idx) +: 8];
    else if (idx <= PAD_LAST)      return PAD_BYTE;
    else                           return FILL;
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane[l] = entry(ptr + PTR_W'(l));
  end

endmodule

// File: rtl/id_port.sv
module id_port #(
  parameter int unsigned        ADDR_W     = 12,
  parameter int unsigned        PTR_W      = 8,
  parameter logic [ADDR_W-1:0]  LO_OFS     = 12'h800,
  parameter logic [ADDR_W-1:0]  HI_OFS     = 12'h801,
  parameter logic [ADDR_W-1:0]  REWIND_OFS = 12'h802
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_wide,
  output logic [15:0]       rd_data
);
  import id_port_pkg::*;

  acc_e                   kind_now;
  acc_e                   step_kind;
  logic                   step;
  logic [PTR_W-1:0]       ptr_q;
  logic [LANES-1:0][7:0]  lane;

  id_port_decode #(
    .ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS), .REWIND_OFS(REWIND_OFS)
  ) u_dec (
    .addr(rd_addr), .wide(rd_wide), .kind(kind_now)
  );

  id_port_strobe u_stb (
    .clk(clk), .rst_n(rst_n), .strobe(rd_strobe),
    .kind_now(kind_now), .step(step), .step_kind(step_kind)
  );

  id_port_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step(step), .step_kind(step_kind), .ptr(ptr_q)
  );

  id_port_rom #(.PTR_W(PTR_W)) u_rom (
    .ptr(ptr_q), .lane(lane)
  );

  always_comb begin
    rd_data = '0;
    if (rd_strobe) begin
      unique case (kind_now)
        ACC_LO:   rd_data = {8'h00, lane[0]};
        ACC_HI:   rd_data = {lane[0], 8'h00};
        ACC_WORD: rd_data = {lane[1], lane[0]};
        default:  rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/id_port_chk.sv
module id_port_chk #(
  parameter int unsigned        ADDR_W     = 12,
  parameter int unsigned        PTR_W      = 8,
  parameter logic [ADDR_W-1:0]  LO_OFS     = 12'h800,
  parameter logic [ADDR_W-1:0]  HI_OFS     = 12'h801,
  parameter logic [ADDR_W-1:0]  REWIND_OFS = 12'h802
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_strobe,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_wide,
  input logic [15:0]       rd_data,
  input logic [PTR_W-1:0]  ptr
);
  logic              seen_q;
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_wide;
  logic              fell;
  logic              cap_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      cap_addr <= '0;
      cap_wide <= 1'b0;
    end else begin
      seen_q <= rd_strobe;
      if (rd_strobe && !seen_q) begin
        cap_addr <= rd_addr;
        cap_wide <= rd_wide;
      end
    end
  end

  assign fell     = seen_q && !rd_strobe;
  assign cap_data = (cap_addr == LO_OFS) || (cap_addr == HI_OFS);

  p_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fell && cap_addr == REWIND_OFS) |=> (ptr == '0));

  p_byte_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fell && cap_data && !cap_wide) |=> (ptr == $past(ptr) + PTR_W'(1)));

  p_word_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fell && cap_data && cap_wide) |=> (ptr == $past(ptr) + PTR_W'(2)));

  p_held_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && $past(rd_strobe)) |-> ($stable(ptr) && $stable(rd_data)));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe) |-> (rd_data == 16'h0000));

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fell && !cap_data && cap_addr != REWIND_OFS) |=> $stable(ptr));

endmodule

bind id_port id_port_chk #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS),
  .REWIND_OFS(REWIND_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
  .rd_wide(rd_wide), .rd_data(rd_data), .ptr(ptr_q)
);

// File: tb/tb_id_port.sv
module tb_id_port;
  localparam logic [63:0] BOARD = "NAVIO-16";

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_strobe = 1'b0;
  logic [11:0] rd_addr = 12'h000;
  logic        rd_wide = 1'b0;
  logic [15:0] rd_data;

  int vectors = 0;
  int misses  = 0;
  int model_ptr = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  event        sample_ev;

  always #10 clk = ~clk;

  id_port dut (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
    .rd_addr(rd_addr), .rd_wide(rd_wide), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_entry(input int i);
    int k;
    k = i % 256;
    case (k)
      0: return 8'h60;
      1: return 8'h61;
      2: return 8'h35;
      3: return 8'h14;
      4: return 8'h03;
      5: return 8'h01;
      default: begin
        if (k < 10)       return 8'h00;
        else if (k < 18)  return BOARD[8*(7-(k-10)) +: 8];
        else if (k < 20)  return 8'h00;
        else              return 8'hFF;
      end
    endcase
  endfunction

  // monitor: pops the scoreboard at each sample point
  initial begin
    forever begin
      @(sample_ev);
      vectors++;
      if (exp_q.size() == 0) begin
        misses++;
        $display("FAIL %s: act %h exp <empty queue>", "scoreboard", rd_data);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          misses++;
          $display("FAIL %s: act %h exp %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic expect_now(input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    ->sample_ev;
    #1;
  endtask

  // one access: strobe held 'hold' cycles, data sampled on the last low clock phase
  task automatic do_read(input logic [11:0] a, input logic w, input int hold,
                         input string t);
    logic [15:0] e;
    @(negedge clk);
    rd_addr = a; rd_wide = w; rd_strobe = 1'b1;
    e = 16'h0000;
    if (a == 12'h800 || a == 12'h801) begin
      if (w)               e = {exp_entry(model_ptr + 1), exp_entry(model_ptr)};
      else if (a == 12'h800) e = {8'h00, exp_entry(model_ptr)};
      else                 e = {exp_entry(model_ptr), 8'h00};
    end
    for (int c = 1; c < hold; c++) begin
      @(negedge clk);
      if (c == 1) expect_now(e, "R10 held strobe data");
    end
    expect_now(e, t);
    @(negedge clk);
    rd_strobe = 1'b0;
    if (a == 12'h802) model_ptr = 0;
    else if (a == 12'h800 || a == 12'h801) model_ptr = (model_ptr + (w ? 2 : 1)) % 256;
    @(negedge clk);
    expect_now(16'h0000, "R11 idle output");
  endtask

  initial begin
    #(20 * 150000);
    misses++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now(16'h0000, "R11 reset idle");

    do_read(12'h800, 1'b0, 1, "R1 first read 60h");
    do_read(12'h801, 1'b0, 1, "R4 high lane byte");
    do_read(12'h800, 1'b1, 1, "R8 word 1435h / R5");
    do_read(12'h801, 1'b1, 1, "R8 word at 801h / R6 revision");
    do_read(12'h802, 1'b0, 1, "R2 rewind data zero");
    do_read(12'h800, 1'b1, 1, "R2 after rewind word 6160h");
    do_read(12'h800, 1'b0, 5, "R10 held byte read");
    do_read(12'h800, 1'b0, 1, "R10 single step after hold");
    do_read(12'h803, 1'b0, 1, "R11 unmapped zero");
    do_read(12'h7FF, 1'b1, 3, "R11 unmapped wide zero");
    do_read(12'h800, 1'b0, 1, "R11 pointer unchanged");
    do_read(12'h802, 1'b1, 2, "R2 rewind wide");

    for (int i = 0; i < 256; i++) begin
      if (i < 4)        do_read(12'h800, 1'b0, 1, "R5 id bytes");
      else if (i < 10)  do_read(12'h801, 1'b0, 1, "R6 revision/dc");
      else              do_read(12'h800, 1'b0, 1, "R7 name/pad/fill R3");
    end
    do_read(12'h800, 1'b0, 1, "R9 wrap to entry 0");

    do_read(12'h802, 1'b0, 1, "R2 rewind");
    for (int i = 0; i < 255; i++) do_read(12'h801, 1'b0, 1, "R4 walk");
    do_read(12'h800, 1'b1, 1, "R9 word across wrap 60FFh");
    do_read(12'h800, 1'b0, 1, "R9 pointer at 1 after wrap");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule